// File: doc/BRIEF.md
# Left-Channel Serial Audio Fetcher with Tick Decimation

This block takes the serial output of an audio ADC that sends words MSB first, left-justified to the frame clock. It brings the bit clock, frame clock and data line into the system clock domain, then shifts in the left-channel word one bit per bit-clock rising edge. When the left half-frame ends, it keeps the word. The right half-frame is never captured.

A free-running divider on the system clock produces a low-rate tick, 5 kHz with the default divider. On each tick the block takes the most recently kept left word and reduces it from signed 16-bit to 8-bit offset binary. It presents that byte with a strobe that lasts one clock. This reduces a 48 kHz codec stream to the tick rate by picking samples, with no filtering. A downstream consumer reads one byte for each strobe.

The capture state machine has three states. `CAP_SYNC` is entered from reset. It moves to `CAP_RIGHT` on the first exit from the left phase that it sees, so a left phase already in progress at reset is skipped. `CAP_RIGHT` moves to `CAP_LEFT` when the frame clock enters the left level. `CAP_LEFT` shifts bits in and returns to `CAP_RIGHT` when the frame clock leaves the left level. The output state machine has two states. It moves from `OUT_EMPTY` to `OUT_READY` when the first word is kept, and stays in `OUT_READY` until reset.

Top module: `audio_left_decimator`

## Requirements
- R1: While reset is held and directly after it, `smp_valid` is 0 and `smp_out` is 8'h00.
- R2: The left phase is the frame clock at logic 1. Data is taken on each bit-clock rising edge in the left phase, and the first bit taken is the word's MSB (bit 15).
- R3: Only the first 16 bits of a left phase enter the word; later bits in the same left phase are ignored. Data during the right phase (frame clock 0) is ignored.
- R4: A word is kept only if a full 16 bits arrived before the frame clock left the left level. A shorter left phase is discarded, and the previously kept word stays.
- R5: The first left phase that the block sees after reset is never captured. Capture starts with the left phase that follows.
- R6: A tick occurs every `TICK_DIV` system clocks. `smp_valid` is high for exactly one clock, and consecutive strobes are exactly `TICK_DIV` clocks apart.
- R7: No strobe is produced until a word has been kept.
- R8: `smp_out` equals {~w[15], w[14:8]} of the kept word w, which is the signed upper byte converted to offset binary.
- R9: On each tick the current kept word is emitted again, until a new word replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bclk | input | 1 | Serial bit clock from the ADC (asynchronous) |
| ser_frame | input | 1 | Frame clock, 1 = left half-frame (asynchronous) |
| ser_data | input | 1 | Serial ADC data, MSB first |
| smp_out | output | 8 | Decimated offset-binary sample |
| smp_valid | output | 1 | One-clock strobe marking a new `smp_out` |

## Verification
The embedded assertions check the following on every cycle:
- the strobe is a single-cycle pulse that always follows a tick;
- no strobe comes out of the empty state;
- the bit counter never passes the word width;
- a word is kept only on an exit from the left state;
- the output byte changes only together with a strobe.

Only the bench scenarios can show the following:
- the bit order and the field of the word that is used;
- that trailing bits, right-channel data and short left phases are dropped;
- that the left phase in progress at reset is skipped;
- the exact value of the offset-binary conversion.

// File: rtl/adc_pkg.sv
package adc_pkg;

    typedef enum logic [1:0] {
        CAP_SYNC  = 2'd0,
        CAP_RIGHT = 2'd1,
        CAP_LEFT  = 2'd2
    } cap_state_t;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_READY = 1'b1
    } out_state_t;

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/left_word_capture.sv
module left_word_capture
    import adc_pkg::*;
#(
    parameter int   WORD_W     = 16,
    parameter logic LEFT_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_s,
    input  logic              frame_s,
    input  logic              data_s,
    output logic [WORD_W-1:0] word_q,
    output logic              word_stb
);

    localparam int          CW   = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] FULL = CW'(WORD_W);

    cap_state_t        state, nxt;
    logic              bclk_d, left_d;
    logic [CW-1:0]     bit_cnt;
    logic [WORD_W-1:0] shreg;

    logic left_now, bclk_rise, enter_left, leave_left;

    assign left_now   = (frame_s == LEFT_LEVEL);
    assign bclk_rise  = bclk_s & ~bclk_d;
    assign enter_left = left_now & ~left_d;
    assign leave_left = ~left_now & left_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d <= 1'b0;
            left_d <= 1'b0;
        end else begin
            bclk_d <= bclk_s;
            left_d <= left_now;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CAP_SYNC;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CAP_SYNC:  if (leave_left) nxt = CAP_RIGHT;
            CAP_RIGHT: if (enter_left) nxt = CAP_LEFT;
            CAP_LEFT:  if (leave_left) nxt = CAP_RIGHT;
            default:   nxt = CAP_SYNC;
        endcase
    end

    // shift register, bit counter and kept word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            word_q   <= '0;
            word_stb <= 1'b0;
        end else begin
            word_stb <= 1'b0;
            unique case (state)
                CAP_SYNC: begin
                    bit_cnt <= '0;
                end
                CAP_RIGHT: begin
                    if (enter_left) bit_cnt <= '0;
                end
                CAP_LEFT: begin
                    if (leave_left) begin
                        if (bit_cnt == FULL) begin
                            word_q   <= shreg;
                            word_stb <= 1'b1;
                        end
                    end else if (bclk_rise && bit_cnt < FULL) begin
                        shreg   <= {shreg[WORD_W-2:0], data_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: bit_cnt <= '0;
            endcase
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= FULL);  // R3

    AST_KEEP_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> ($past(state) == CAP_LEFT && state == CAP_RIGHT));  // R4

    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !word_stb |-> $stable(word_q));  // R4

endmodule

// File: rtl/rate_tick.sv
module rate_tick #(
    parameter int DIV = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int            CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);  // R6

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);  // R6

endmodule

// File: rtl/sample_requant.sv
module sample_requant
    import adc_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int OUT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] word_q,
    output logic [OUT_W-1:0]  smp_out,
    output logic              smp_valid
);

    out_state_t       state, nxt;
    logic [OUT_W-1:0] reduced;

    // signed upper field to offset binary
    assign reduced = {~word_q[WORD_W-1], word_q[WORD_W-2 -: OUT_W-1]};

    always_ff @(posedge clk) begin
        if (!rst_n) state <= OUT_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            OUT_EMPTY: if (word_stb) nxt = OUT_READY;
            OUT_READY: nxt = OUT_READY;
            default:   nxt = OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_out   <= '0;
            smp_valid <= 1'b0;
        end else begin
            smp_valid <= 1'b0;
            unique case (state)
                OUT_EMPTY: ;
                OUT_READY: begin
                    if (tick) begin
                        smp_out   <= reduced;
                        smp_valid <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_NO_EMPTY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OUT_EMPTY) |=> !smp_valid);  // R7

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> $stable(smp_out));  // R9

endmodule

// File: rtl/audio_left_decimator.sv
module audio_left_decimator #(
    parameter int TICK_DIV    = 10000,
    parameter int WORD_W      = 16,
    parameter int OUT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_bclk,
    input  logic             ser_frame,
    input  logic             ser_data,
    output logic [OUT_W-1:0] smp_out,
    output logic             smp_valid
);

    logic [2:0]        raw_in, synced;
    logic [WORD_W-1:0] word_q;
    logic              word_stb;
    logic              tick;

    assign raw_in = {ser_data, ser_frame, ser_bclk};

    bit_sync #(
        .WIDTH (3),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (synced)
    );

    left_word_capture #(
        .WORD_W    (WORD_W),
        .LEFT_LEVEL(1'b1)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_s  (synced[0]),
        .frame_s (synced[1]),
        .data_s  (synced[2]),
        .word_q  (word_q),
        .word_stb(word_stb)
    );

    rate_tick #(
        .DIV(TICK_DIV)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    sample_requant #(
        .WORD_W(WORD_W),
        .OUT_W (OUT_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .word_stb (word_stb),
        .word_q   (word_q),
        .smp_out  (smp_out),
        .smp_valid(smp_valid)
    );

    AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(tick));  // R6

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);  // R6

endmodule

// File: tb/test_audio_left_decimator.sv
module test_audio_left_decimator;

    localparam int TICK_DIV = 400;
    localparam int HALF_BC  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bclk = 1'b0;
    logic       ser_frame = 1'b1;
    logic       ser_data = 1'b0;
    logic [7:0] smp_out;
    logic       smp_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int n_valid = 0;
    int since   = 0;
    bit have_prev = 1'b0;
    bit prev_v    = 1'b0;

    always #5 clk = ~clk;

    audio_left_decimator #(.TICK_DIV(TICK_DIV)) i_audio_left_decimator (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_bclk (ser_bclk),
        .ser_frame(ser_frame),
        .ser_data (ser_data),
        .smp_out  (smp_out),
        .smp_valid(smp_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // strobe monitor: width and spacing (R6)
    always @(negedge clk) begin
        if (rst_n) begin
            since++;
            if (smp_valid) begin
                n_valid++;
                check(!prev_v, "R6 strobe width", 2, 1);
                if (have_prev) check(since == TICK_DIV, "R6 spacing", since, TICK_DIV);
                have_prev = 1'b1;
                since = 0;
            end
            prev_v = smp_valid;
        end
    end

    task automatic half(input logic lvl, input logic [19:0] bits, input int n);
        ser_frame = lvl;
        for (int i = 0; i < n; i++) begin
            ser_data = bits[19-i];
            repeat (4) @(negedge clk);
            ser_bclk = 1'b1;
            repeat (4) @(negedge clk);
            ser_bclk = 1'b0;
        end
    endtask

    task automatic send_frame(input logic [15:0] w, input int lbits);
        half(1'b1, {w, 4'b1111}, lbits);
        half(1'b0, 20'hFFFFF, HALF_BC);
        repeat (10) @(negedge clk);
    endtask

    task automatic wait_valid(output logic [7:0] v);
        @(negedge clk);
        while (!smp_valid) @(negedge clk);
        v = smp_out;
    endtask

    task automatic t_reset;
        check(smp_valid == 1'b0, "R1 valid", smp_valid, 0);
        check(smp_out == 8'h00, "R1 sample", smp_out, 0);
    endtask

    task automatic t_skip_first;
        send_frame(16'hABCD, HALF_BC);
        repeat (3 * TICK_DIV) @(negedge clk);
        check(n_valid == 0, "R5 R7 no strobe before first kept word", n_valid, 0);
    endtask

    task automatic t_word(input logic [15:0] w, input logic [7:0] exp, input string req);
        logic [7:0] v;
        send_frame(w, HALF_BC);
        wait_valid(v);
        check(v == exp, req, v, exp);
    endtask

    task automatic t_short;
        logic [7:0] v;
        send_frame(16'h0000, 10);
        wait_valid(v);
        check(v == 8'h70, "R4 short left phase dropped", v, 8'h70);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        for (int k = 0; k < 3; k++) begin
            wait_valid(v);
            check(v == 8'h70, "R9 re-emit held word", v, 8'h70);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_skip_first();
        t_word(16'h1234, 8'h92, "R2 R8 MSB-first capture");
        t_word(16'h7FFF, 8'hFF, "R8 max positive");
        t_word(16'h8000, 8'h00, "R8 max negative");
        t_word(16'h00FF, 8'h80, "R8 low byte dropped");
        t_word(16'hF0A5, 8'h70, "R3 trailing and right bits ignored");
        t_short();
        t_hold();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule